// File: doc/BRIEF.md
# Load/Store Address Overlap Matrix

This block watches a small set of in-flight memory operations and reports, for every pair of them, whether their byte ranges may touch the same memory. Each entry slot is loaded through its own write port with the low address bits of an access and its length. The slot turns these into a line number (a slice of the address above the byte offset) and a byte-enable run shifted to the access's offset inside the line. The run may spill into the following line. A slot stays occupied until its clear input removes it.

The comparison is conservative by design. Only the line-local part of the address is supplied, so two accesses that differ only in higher bits are reported as overlapping. A real overlap is never missed. Byte overlap is found by ANDing masks rather than by comparing binary addresses. The triangle of pair comparators is mirrored into a full square matrix. An ordering unit uses this matrix to keep overlapping operations in program order.

Top module: `lsq_overlap_matrix`

## Requirements
- R1: After reset every slot is empty and every bit of `conflict_o` is 0.
- R2: The length code is 00 for 1 byte, 01 for 2 bytes, 10 for 4 bytes and 11 for 8 bytes. An access covers the bytes from its offset (address bits [3:0]) upward for that many bytes. Two accesses on the same line conflict exactly when their covered bytes share at least one byte; adjacent ranges that share no byte do not conflict.
- R3: Two 8-byte accesses at addresses 0x001 and 0x002 are reported as conflicting.
- R4: Accesses whose line numbers (address bits [10:4]) differ, and that do not spill into each other's line, do not conflict, even if their offsets are equal.
- R5: An access whose bytes run past offset 15 also covers the first bytes of the next line number. It conflicts with an access on that next line that shares a byte. The line number after 0x7F is 0x00. This holds whichever of the two slots has the lower index.
- R6: A cleared or never-written slot conflicts with no other slot. A clear takes effect for the cycle after the clock edge that samples it.
- R7: When a slot's write and clear inputs are both high at the same edge, the clear wins and the slot is empty afterwards.
- R8: `conflict_o[i][j]` equals `conflict_o[j][i]`, and `conflict_o[i][i]` is always 0.
- R9: A write to an occupied slot replaces its address and length, and the conflicts follow the new contents from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | N_ENT | Per-slot load strobe |
| wr_addr_i | input | N_ENT x ADDR_W | Per-slot line-local address (bits [10:0] by default) |
| wr_len_i | input | N_ENT x 2 | Per-slot length code |
| clr_i | input | N_ENT | Per-slot clear strobe, overrides the load strobe |
| conflict_o | output | N_ENT x N_ENT | Pairwise conflict matrix, registered-state based |

## Verification
The embedded properties check a few things on every cycle. A slot with any conflict bit set must be occupied. A clear empties its slot and blanks its row. An occupied slot holds a mask of 1, 2, 4 or 8 set bits. A load without a clear leaves the slot occupied. Whether a given pair should conflict depends on exact byte arithmetic, so only the bench's scenarios can show it. These scenarios cover adjacent and overlapping ranges, different lines, a spill past the line end (including the wrap from the last line number to line zero) and a write colliding with a clear. The bench checks them against a byte-level model modulo the 2048-byte window, and it checks symmetry and the zero diagonal on every sampled matrix.

// File: rtl/lsq_ovl_pkg.sv
package lsq_ovl_pkg;

  typedef enum logic [1:0] {
    LEN_B1 = 2'b00,
    LEN_B2 = 2'b01,
    LEN_B4 = 2'b10,
    LEN_B8 = 2'b11
  } acc_len_e;

  localparam int unsigned ACC_MAX_BYTES = 8;

  // Unary run of ones, one per accessed byte
  function automatic logic [ACC_MAX_BYTES-1:0] len_run(input logic [1:0] len);
    logic [ACC_MAX_BYTES-1:0] run;
    case (acc_len_e'(len))
      LEN_B1:  run = 8'h01;
      LEN_B2:  run = 8'h03;
      LEN_B4:  run = 8'h0F;
      default: run = 8'hFF;
    endcase
    return run;
  endfunction

endpackage

// File: rtl/lsq_ovl_entry.sv
module lsq_ovl_entry
  import lsq_ovl_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned OFS_W  = 4,
  localparam int unsigned LINE_BYTES = 1 << OFS_W,
  localparam int unsigned MASK_W     = LINE_BYTES + ACC_MAX_BYTES,
  localparam int unsigned SLICE_W    = ADDR_W - OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               clr,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [1:0]         wr_len,
  output logic               valid_o,
  output logic [SLICE_W-1:0] slice_o,
  output logic [MASK_W-1:0]  mask_o
);

  logic               valid_q, valid_d;
  logic [SLICE_W-1:0] slice_q, slice_d;
  logic [MASK_W-1:0]  mask_q,  mask_d;
  logic               load_en;

  always_comb begin
    load_en = wr_en & ~clr;
    valid_d = valid_q;
    if (clr)
      valid_d = 1'b0;
    else if (wr_en)
      valid_d = 1'b1;
    slice_d = wr_addr[ADDR_W-1:OFS_W];
    mask_d  = MASK_W'(len_run(wr_len)) << wr_addr[OFS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= 1'b0;
    else
      valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      slice_q <= slice_d;
      mask_q  <= mask_d;
    end
  end

  assign valid_o = valid_q;
  assign slice_o = slice_q;
  assign mask_o  = mask_q;

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !valid_q);

  // R9
  load_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> valid_q);

  // R2
  mask_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($countones(mask_q) == 1 || $countones(mask_q) == 2 ||
                 $countones(mask_q) == 4 || $countones(mask_q) == 8));

endmodule

// File: rtl/lsq_ovl_pair.sv
module lsq_ovl_pair #(
  parameter int unsigned SLICE_W    = 7,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned MASK_W     = 24,
  localparam int unsigned SPILL_W   = MASK_W - LINE_BYTES
) (
  input  logic               a_valid,
  input  logic [SLICE_W-1:0] a_slice,
  input  logic [MASK_W-1:0]  a_mask,
  input  logic               b_valid,
  input  logic [SLICE_W-1:0] b_slice,
  input  logic [MASK_W-1:0]  b_mask,
  output logic               hit_o
);

  logic [LINE_BYTES-1:0] a_lo, b_lo;
  logic [SPILL_W-1:0]    a_hi, b_hi;
  logic                  same_line, a_before_b, b_before_a;
  logic                  same_hit, a_spill_hit, b_spill_hit;

  always_comb begin
    a_lo = a_mask[LINE_BYTES-1:0];
    b_lo = b_mask[LINE_BYTES-1:0];
    a_hi = a_mask[MASK_W-1:LINE_BYTES];
    b_hi = b_mask[MASK_W-1:LINE_BYTES];
    same_line  = (a_slice == b_slice);
    a_before_b = (SLICE_W'(a_slice + 1'b1) == b_slice);
    b_before_a = (SLICE_W'(b_slice + 1'b1) == a_slice);
    same_hit    = same_line && ((|(a_lo & b_lo)) || (|(a_hi & b_hi)));
    a_spill_hit = a_before_b && (|(a_hi & b_lo[SPILL_W-1:0]));
    b_spill_hit = b_before_a && (|(b_hi & a_lo[SPILL_W-1:0]));
    hit_o = a_valid && b_valid && (same_hit || a_spill_hit || b_spill_hit);
  end

endmodule

// File: rtl/lsq_overlap_matrix.sv
module lsq_overlap_matrix
  import lsq_ovl_pkg::*;
#(
  parameter int unsigned N_ENT  = 4,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned OFS_W  = 4,
  localparam int unsigned LINE_BYTES = 1 << OFS_W,
  localparam int unsigned MASK_W     = LINE_BYTES + ACC_MAX_BYTES,
  localparam int unsigned SLICE_W    = ADDR_W - OFS_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_ENT-1:0]               wr_en_i,
  input  logic [N_ENT-1:0][ADDR_W-1:0]   wr_addr_i,
  input  logic [N_ENT-1:0][1:0]          wr_len_i,
  input  logic [N_ENT-1:0]               clr_i,
  output logic [N_ENT-1:0][N_ENT-1:0]    conflict_o
);

  logic [N_ENT-1:0]               ent_valid;
  logic [N_ENT-1:0][SLICE_W-1:0]  ent_slice;
  logic [N_ENT-1:0][MASK_W-1:0]   ent_mask;
  logic [N_ENT-1:0][N_ENT-1:0]    tri_hit;

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
    lsq_ovl_entry #(
      .ADDR_W (ADDR_W),
      .OFS_W  (OFS_W)
    ) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i[gi]),
      .clr     (clr_i[gi]),
      .wr_addr (wr_addr_i[gi]),
      .wr_len  (wr_len_i[gi]),
      .valid_o (ent_valid[gi]),
      .slice_o (ent_slice[gi]),
      .mask_o  (ent_mask[gi])
    );
  end

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_row
    for (genvar gj = 0; gj < N_ENT; gj++) begin : g_col
      if (gi < gj) begin : g_cmp
        lsq_ovl_pair #(
          .SLICE_W    (SLICE_W),
          .LINE_BYTES (LINE_BYTES),
          .MASK_W     (MASK_W)
        ) u_pair (
          .a_valid (ent_valid[gi]),
          .a_slice (ent_slice[gi]),
          .a_mask  (ent_mask[gi]),
          .b_valid (ent_valid[gj]),
          .b_slice (ent_slice[gj]),
          .b_mask  (ent_mask[gj]),
          .hit_o   (tri_hit[gi][gj])
        );
        assign conflict_o[gi][gj] = tri_hit[gi][gj];
      end else if (gi > gj) begin : g_mirror
        assign tri_hit[gi][gj]    = 1'b0;
        assign conflict_o[gi][gj] = tri_hit[gj][gi];
      end else begin : g_diag
        assign tri_hit[gi][gj]    = 1'b0;
        assign conflict_o[gi][gj] = 1'b0;
      end
    end
  end

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_chk
    // R6
    row_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|conflict_o[gi]) |-> ent_valid[gi]);

    // R6
    clear_blanks_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[gi] |=> (conflict_o[gi] == '0));
  end

endmodule

// File: tb/lsq_overlap_matrix_tb.sv
`timescale 1ns/1ps
module lsq_overlap_matrix_tb;

  localparam int N = 4;
  localparam int AW = 11;
  localparam int WIN = 1 << AW;

  logic                   clk;
  logic                   rst_n;
  logic [N-1:0]           wr_en;
  logic [N-1:0][AW-1:0]   wr_addr;
  logic [N-1:0][1:0]      wr_len;
  logic [N-1:0]           clr;
  logic [N-1:0][N-1:0]    conflict;

  lsq_overlap_matrix #(.N_ENT(N), .ADDR_W(AW), .OFS_W(4)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_len_i   (wr_len),
    .clr_i      (clr),
    .conflict_o (conflict)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  // bench reference state
  bit m_valid [N];
  int m_addr  [N];
  int m_len   [N];

  // staged stimulus for the next commit
  bit st_en  [N];
  int st_addr[N];
  int st_len [N];
  bit st_clr [N];

  logic [N*N-1:0] exp_q [$];
  string          tag_q [$];

  function automatic bit bytes_meet(int a, int la, int b, int lb);
    for (int k = 0; k < (1 << la); k++)
      for (int m = 0; m < (1 << lb); m++)
        if (((a + k) % WIN) == ((b + m) % WIN)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [N*N-1:0] model_matrix();
    logic [N*N-1:0] e;
    e = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j && m_valid[i] && m_valid[j] &&
            bytes_meet(m_addr[i], m_len[i], m_addr[j], m_len[j]))
          e[i*N + j] = 1'b1;
    return e;
  endfunction

  task automatic stage_wr(int i, int addr, int len);
    st_en[i] = 1'b1; st_addr[i] = addr; st_len[i] = len;
  endtask

  task automatic stage_clr(int i);
    st_clr[i] = 1'b1;
  endtask

  task automatic commit(string tag);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      wr_en[i]   = st_en[i];
      wr_addr[i] = AW'(st_addr[i]);
      wr_len[i]  = 2'(st_len[i]);
      clr[i]     = st_clr[i];
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      if (st_clr[i]) m_valid[i] = 1'b0;
      else if (st_en[i]) begin
        m_valid[i] = 1'b1; m_addr[i] = st_addr[i]; m_len[i] = st_len[i];
      end
      st_en[i] = 1'b0; st_clr[i] = 1'b0;
    end
    wr_en = '0; clr = '0;
    exp_q.push_back(model_matrix());
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [N*N-1:0] exp_m;
      logic [N*N-1:0] act_m;
      string t;
      bit sym_ok;
      exp_m = exp_q.pop_front();
      t = tag_q.pop_front();
      act_m = conflict;
      n_checks++;
      if (act_m !== exp_m) begin
        n_errors++;
        $display("FAIL %s: actual=%h expected=%h", t, act_m, exp_m);
      end
      sym_ok = 1'b1;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (conflict[i][j] !== conflict[j][i] || (i == j && conflict[i][j] !== 1'b0))
            sym_ok = 1'b0;
      n_checks++;
      if (!sym_ok) begin
        n_errors++;
        $display("FAIL R8 symmetry/diagonal (%s): actual=%h expected=symmetric with zero diagonal", t, act_m);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = '0; clr = '0; wr_addr = '0; wr_len = '0;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_addr[i] = 0; m_len[i] = 0;
      st_en[i] = 0; st_addr[i] = 0; st_len[i] = 0; st_clr[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    exp_q.push_back('0);
    tag_q.push_back("R1 reset state");

    // R3: 8B at 0x001 vs 8B at 0x002
    stage_wr(0, 'h001, 3); stage_wr(1, 'h002, 3);
    commit("R3 overlapping 8-byte stores");

    // R2: adjacent single bytes, no shared byte
    stage_clr(0); stage_clr(1);
    stage_wr(2, 'h003, 0); stage_wr(3, 'h004, 0);
    commit("R2 adjacent bytes, R6 clear");

    // R9/R2: rewrite slot 3 as 2B at 0x002 covering byte 3
    stage_wr(3, 'h002, 1);
    commit("R9 rewrite, R2 two-byte overlap");

    // R2: 4B at 0x004 and 1B at 0x008 touch nothing
    stage_wr(0, 'h004, 2); stage_wr(1, 'h008, 0);
    commit("R2 four-byte boundary");

    // R4: same offset, next line number
    stage_wr(1, 'h014, 2);
    commit("R4 different line same offset");

    // R6: clear three slots, spill access in slot 1
    stage_clr(0); stage_clr(2); stage_clr(3);
    stage_wr(1, 'h00F, 3);
    commit("R6 cleared slots");

    // R5: spill covers 0x010..0x016
    stage_wr(2, 'h016, 0); stage_wr(3, 'h017, 0);
    commit("R5 spill into next line");

    // R7: write and clear together on slot 0
    stage_wr(0, 'h010, 0); stage_clr(0);
    commit("R7 clear beats write");

    // R5 wrap: 8B at 0x7FF covers 0x7FF..0x006
    stage_clr(1); stage_clr(2); stage_clr(3);
    stage_wr(0, 'h7FF, 3);
    commit("R6 clear before wrap");
    stage_wr(3, 'h003, 0); stage_wr(1, 'h007, 0);
    commit("R5 wrap last line to line zero");

    // R5: spill from the higher-index slot
    stage_clr(1); stage_wr(3, 'h02C, 3); stage_wr(0, 'h032, 1);
    commit("R5 spill from higher slot");

    // R6: lone slot conflicts with nothing
    stage_clr(3);
    commit("R6 single valid slot");

    // R4: equal offsets on distant lines
    stage_wr(1, 'h155, 0); stage_wr(2, 'h255, 0); stage_wr(3, 'h055, 0);
    commit("R4 distant lines");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule